// File: doc/BRIEF.md
# Truth-Table Boolean Execution Unit

This unit executes the boolean instruction group of a 36-bit accumulator machine. It takes a 9-bit opcode, an accumulator operand, a memory operand and an 18-bit effective address. It returns a 36-bit result, together with strobes that say whether the result goes to the accumulator, to memory, or to both. The unit has no ALU decode. Four bits of the opcode form a truth table. At every bit position, the accumulator bit and the memory-operand bit select one entry of that table through a 4-to-1 multiplexer, so any of the sixteen two-input boolean functions can be encoded.

An instruction is offered with `in_valid`. It is taken on any rising edge where `in_ready` is also high, and the outputs appear one cycle later. A two-state controller follows this. In state IDLE, an accepted instruction leads to EMIT and no acceptance keeps IDLE. In state EMIT, an accepted instruction keeps EMIT, so instructions can run back to back, and no acceptance returns to IDLE. `done` is high exactly while the controller is in EMIT.

Top module: `bool_truth_unit`

## Requirements
- R1: The group is recognised when opcode bits 8:6 equal 3'b100. An accepted opcode outside the group still produces a `done` pulse, but the result is zero and both strobes stay low.
- R2: Opcode bits 5:2 form the function table F, with F[0] = opcode bit 2. Result bit i equals F[{~M[i], ~A[i]}]. Examples: F=0001 gives A AND M, F=0011 passes M, F=0101 passes A, F=0000 gives all zeros and F=1111 gives all ones.
- R3: Mode 00 (opcode bits 1:0) raises `acc_we` only.
- R4: In mode 01, the memory operand is replaced by the effective address, zero-extended to 36 bits, and only `acc_we` is raised.
- R5: Mode 10 raises `mem_we` only.
- R6: Mode 11 raises both `acc_we` and `mem_we`.
- R7: After reset, `in_ready` is high. The result, the strobes and `done` belong to the instruction accepted at the previous rising edge, including when instructions arrive in consecutive cycles.
- R8: `done` is high for exactly one cycle per accepted instruction and is low after any cycle with no acceptance. The strobes are never high while `done` is low.
- R9: While reset is active, `done`, both strobes, `result` and `in_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can take an instruction |
| opcode | input | 9 | Group (8:6), function table (5:2), mode (1:0) |
| acc_in | input | 36 | Accumulator operand |
| mem_in | input | 36 | Memory operand |
| eaddr | input | 18 | Effective address, used as the operand in mode 01 |
| done | output | 1 | Result and strobes valid this cycle |
| result | output | 36 | Boolean result |
| acc_we | output | 1 | Write the result to the accumulator |
| mem_we | output | 1 | Write the result to memory |

## Verification
Two things can happen in the same cycle: a new instruction is accepted while the result of the previous one is on the outputs in state EMIT. The bench offers instructions on consecutive cycles throughout, so the controller stays in EMIT. Each result and strobe pair is compared against the model value of the instruction accepted one edge earlier, never the one currently on the inputs. Idle gaps and foreign opcodes are mixed into the stream to judge the EMIT-to-IDLE transition, and to judge that a `done` pulse does not drag stale strobes along with it.

// File: rtl/bool_unit_pkg.sv
package bool_unit_pkg;

    localparam int OPC_W     = 9;
    localparam int FUNC_W    = 4;
    localparam logic [2:0] GROUP_CODE = 3'b100;

    typedef enum logic [1:0] {
        MODE_TO_ACC  = 2'b00,
        MODE_IMM     = 2'b01,
        MODE_TO_MEM  = 2'b10,
        MODE_TO_BOTH = 2'b11
    } wb_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } fsm_state_e;

endpackage

// File: rtl/bool_operand_sel.sv
module bool_operand_sel
    import bool_unit_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 18
) (
    input  wb_mode_e            mode,
    input  logic [WORD_W-1:0]   mem_in,
    input  logic [ADDR_W-1:0]   eaddr,
    output logic [WORD_W-1:0]   m_opnd
);
    localparam int PAD_W = WORD_W - ADDR_W;

    logic [WORD_W-1:0] imm_ext;

    assign imm_ext = {{PAD_W{1'b0}}, eaddr};

    always_comb begin
        if (mode == MODE_IMM) begin
            m_opnd = imm_ext;
        end else begin
            m_opnd = mem_in;
        end
    end
endmodule

// File: rtl/bool_mux_array.sv
module bool_mux_array
    import bool_unit_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic [FUNC_W-1:0]   table_bits,
    input  logic [WORD_W-1:0]   a_opnd,
    input  logic [WORD_W-1:0]   m_opnd,
    output logic [WORD_W-1:0]   r_out
);
    for (genvar g = 0; g < WORD_W; g++) begin : g_bit
        logic [1:0] pick;
        assign pick     = {~m_opnd[g], ~a_opnd[g]};
        assign r_out[g] = table_bits[pick];
    end
endmodule

// File: rtl/bool_ctrl_fsm.sv
module bool_ctrl_fsm
    import bool_unit_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     accept,
    input  logic     group_hit,
    input  wb_mode_e mode,
    output logic     done,
    output logic     acc_we,
    output logic     mem_we
);
    fsm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = accept ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_we <= 1'b0;
            mem_we <= 1'b0;
        end else if (accept) begin
            acc_we <= group_hit && (mode != MODE_TO_MEM);
            mem_we <= group_hit && (mode == MODE_TO_MEM || mode == MODE_TO_BOTH);
        end else begin
            acc_we <= 1'b0;
            mem_we <= 1'b0;
        end
    end

    assign done = (state_q == ST_EMIT);
endmodule

// File: rtl/bool_truth_unit.sv
module bool_truth_unit
    import bool_unit_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [OPC_W-1:0]     opcode,
    input  logic [WORD_W-1:0]    acc_in,
    input  logic [WORD_W-1:0]    mem_in,
    input  logic [ADDR_W-1:0]    eaddr,
    output logic                 done,
    output logic [WORD_W-1:0]    result,
    output logic                 acc_we,
    output logic                 mem_we
);
    logic              ready_q;
    logic              accept;
    logic              group_hit;
    wb_mode_e          mode;
    logic [FUNC_W-1:0] table_bits;
    logic [WORD_W-1:0] m_opnd;
    logic [WORD_W-1:0] mux_out;
    logic [WORD_W-1:0] result_q;

    assign group_hit  = (opcode[8:6] == GROUP_CODE);
    assign table_bits = opcode[5:2];
    assign mode       = wb_mode_e'(opcode[1:0]);
    assign accept     = in_valid && ready_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b1;
        end
    end

    bool_operand_sel #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_opsel (
        .mode   (mode),
        .mem_in (mem_in),
        .eaddr  (eaddr),
        .m_opnd (m_opnd)
    );

    bool_mux_array #(
        .WORD_W (WORD_W)
    ) u_mux (
        .table_bits (table_bits),
        .a_opnd     (acc_in),
        .m_opnd     (m_opnd),
        .r_out      (mux_out)
    );

    bool_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .group_hit (group_hit),
        .mode      (mode),
        .done      (done),
        .acc_we    (acc_we),
        .mem_we    (mem_we)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (accept) begin
            result_q <= group_hit ? mux_out : '0;
        end
    end

    assign result   = result_q;
    assign in_ready = ready_q;
endmodule

// File: rtl/bool_truth_unit_chk.sv
module bool_truth_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [8:0] opcode,
    input logic       done,
    input logic       acc_we,
    input logic       mem_we
);
    logic acc_ok;
    assign acc_ok = in_valid && in_ready;

    p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready);

    p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok |=> done);

    p_done_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ok |=> !done);

    p_we_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we || mem_we) |-> done);

    p_foreign_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && opcode[8:6] != 3'b100) |=> (!acc_we && !mem_we));

    p_acc_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && opcode[8:6] == 3'b100 && opcode[1:0] == 2'b00) |=> (acc_we && !mem_we));

    p_imm_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && opcode[8:6] == 3'b100 && opcode[1:0] == 2'b01) |=> (acc_we && !mem_we));

    p_mem_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && opcode[8:6] == 3'b100 && opcode[1:0] == 2'b10) |=> (mem_we && !acc_we));

    p_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && opcode[8:6] == 3'b100 && opcode[1:0] == 2'b11) |=> (mem_we && acc_we));
endmodule

bind bool_truth_unit bool_truth_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .opcode   (opcode),
    .done     (done),
    .acc_we   (acc_we),
    .mem_we   (mem_we)
);

// File: tb/sim_bool_truth_unit.sv
`timescale 1ns/1ps
module sim_bool_truth_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [8:0]  opcode = '0;
    logic [35:0] acc_in = '0;
    logic [35:0] mem_in = '0;
    logic [17:0] eaddr = '0;
    logic        done;
    logic [35:0] result;
    logic        acc_we;
    logic        mem_we;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    bit pend = 1'b0;
    bit running = 1'b0;
    logic [35:0] exp_res;
    logic [1:0]  exp_we;
    logic [8:0]  exp_op;

    always #2 clk = ~clk;

    bool_truth_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .opcode(opcode), .acc_in(acc_in), .mem_in(mem_in), .eaddr(eaddr),
        .done(done), .result(result), .acc_we(acc_we), .mem_we(mem_we)
    );

    // {we(mem,acc)[100:99], opcode[98:90], acc[89:54], mem[53:18], ea[17:0]}
    localparam logic [100:0] VEC [8] = '{
        {2'b01, 9'b100_0001_00, 36'hFF00FF00F, 36'h0F0F0F0F0, 18'h00000},
        {2'b01, 9'b100_0011_01, 36'h123456789, 36'hFFFFFFFFF, 18'h2ABCD},
        {2'b10, 9'b100_0101_10, 36'hA5A5A5A5A, 36'h5A5A5A5A5, 18'h3FFFF},
        {2'b11, 9'b100_1111_11, 36'h000000000, 36'h000000000, 18'h00001},
        {2'b01, 9'b100_0000_00, 36'hFFFFFFFFF, 36'hFFFFFFFFF, 18'h00000},
        {2'b00, 9'b011_0101_11, 36'hFFFFFFFFF, 36'h000000000, 18'h12345},
        {2'b00, 9'b000_1111_10, 36'h800000001, 36'hFFFFFFFFF, 18'h00000},
        {2'b11, 9'b100_0110_11, 36'hCCCCCCCCC, 36'hAAAAAAAAA, 18'h00000}
    };

    function automatic logic [35:0] model_res(input logic [8:0] op, input logic [35:0] a,
                                              input logic [35:0] m, input logic [17:0] ea);
        logic [35:0] mm;
        logic [35:0] r;
        if (op[8:6] != 3'b100) return '0;
        mm = (op[1:0] == 2'b01) ? {18'b0, ea} : m;
        for (int i = 0; i < 36; i++) begin
            case ({mm[i], a[i]})
                2'b11:   r[i] = op[2];
                2'b10:   r[i] = op[3];
                2'b01:   r[i] = op[4];
                default: r[i] = op[5];
            endcase
        end
        return r;
    endfunction

    function automatic logic [1:0] model_we(input logic [8:0] op);
        if (op[8:6] != 3'b100) return 2'b00;
        return {op[1], op[1:0] != 2'b10};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [8:0] op);
        if (op[8:6] != 3'b100) return "R1";
        case (op[1:0])
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic issue(input bit v, input logic [8:0] op, input logic [35:0] a,
                         input logic [35:0] m, input logic [17:0] ea, input logic [1:0] we);
        @(negedge clk);
        if (pend) begin
            chk(done === 1'b1, "R7 done after accept", 64'(done), 64'd1);
            chk(result === exp_res,
                (exp_op[8:6] != 3'b100) ? "R1 result" : (exp_op[1:0] == 2'b01) ? "R4 result" : "R2 result",
                64'(result), 64'(exp_res));
            chk({mem_we, acc_we} === exp_we, mode_tag(exp_op), 64'({mem_we, acc_we}), 64'(exp_we));
        end else if (running) begin
            chk(done === 1'b0, "R8 done after idle", 64'(done), 64'd0);
            chk({mem_we, acc_we} === 2'b00, "R8 strobes after idle", 64'({mem_we, acc_we}), 64'd0);
        end
        running  = 1'b1;
        in_valid = v;
        opcode   = op;
        acc_in   = a;
        mem_in   = m;
        eaddr    = ea;
        pend     = v;
        exp_res  = model_res(op, a, m, ea);
        exp_we   = we;
        exp_op   = op;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done === 1'b0, "R9 done in reset", 64'(done), 64'd0);
        chk({mem_we, acc_we} === 2'b00, "R9 strobes in reset", 64'({mem_we, acc_we}), 64'd0);
        chk(result === 36'd0, "R9 result in reset", 64'(result), 64'd0);
        chk(in_ready === 1'b0, "R9 ready in reset", 64'(in_ready), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready === 1'b1, "R7 ready after reset", 64'(in_ready), 64'd1);

        // table, back to back
        for (int i = 0; i < 8; i++) begin
            issue(1'b1, VEC[i][98:90], VEC[i][89:54], VEC[i][53:18], VEC[i][17:0], VEC[i][100:99]);
        end
        // gap then single
        issue(1'b0, '0, '0, '0, '0, 2'b00);
        issue(1'b0, '0, '0, '0, '0, 2'b00);
        issue(1'b1, 9'b100_0001_00, 36'hFFFFFFFFF, 36'h000000001, 18'h0, 2'b01);
        issue(1'b0, '0, '0, '0, '0, 2'b00);

        // all functions x all modes with random operands, back to back
        for (int f = 0; f < 16; f++) begin
            for (int md = 0; md < 4; md++) begin
                logic [8:0] op;
                op = {3'b100, 4'(f), 2'(md)};
                issue(1'b1, op, {4'($urandom), 32'($urandom)}, {4'($urandom), 32'($urandom)},
                      18'($urandom), model_we(op));
            end
        end
        // foreign opcode between group ones
        issue(1'b1, 9'b111_1111_11, 36'hFFFFFFFFF, 36'hFFFFFFFFF, 18'h3FFFF, 2'b00);
        issue(1'b1, 9'b100_1110_11, 36'h0F0F0F0F0, 36'h00FF00FF0, 18'h0, 2'b11);
        issue(1'b0, '0, '0, '0, '0, 2'b00);
        issue(1'b0, '0, '0, '0, '0, 2'b00);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule